// File: doc/BRIEF.md
# Mailbox Bypass Port Controller

This block is the access decoder and mailbox logic that sits between two clocked ports of a bidirectional FIFO pair. Each port has its own clock and drives an active-low chip select, a write/read direction bit, an enable and a mailbox select. When chip select and enable are both asserted at a rising edge of the port's clock, the block performs one access. With mailbox select low, a write becomes a push into the outbound FIFO and a read becomes a pop from the inbound FIFO. With mailbox select high, the access goes to a single-word bypass register that carries one word straight to the opposite port. The FIFO storage lies outside the block, and the block reaches it only through push/pop strobes qualified by ready inputs.

There is one mailbox register for each direction. Direction 1 runs from port A to port B, and direction 2 runs from port B to port A. Each mailbox has a full flag that the receiving port sees in its own clock domain. A toggle handshake with two-flop synchronizers carries the "loaded" and "taken" events between the clock domains, so the clocks may be unrelated or identical. Each direction has its own asynchronous active-low reset. That reset clears the mailbox of its direction and blocks the FIFO strobes of that direction in both domains.

Top module: `mbx_bypass_ctrl`

## Requirements
- R1: An access happens only at a rising edge where chip select (active low) is 0 and enable is 1. When chip select is 1 or enable is 0, no push, pop or mailbox change takes place.
- R2: A write access (direction bit = 1) with mailbox select = 0 raises the outbound push strobe combinationally, but only when the push-ready input is 1. The push data equals the port's data input.
- R3: A read access (direction bit = 0) with mailbox select = 0 raises the inbound pop strobe when pop-ready is 1. The port's data output then holds the FIFO read data after that edge.
- R4: A mailbox write that is accepted loads the 36-bit register. The receiving port's full flag reads 1 after the second rising edge of the receiving clock that follows the write edge.
- R5: A mailbox write made while the sender-side full state is set is ignored, and the stored word is left unchanged.
- R6: A mailbox read made while the receiving full flag is 1 puts the stored word on the data output after that edge and clears the flag at that edge. With common clocks, a sender write on the second edge after the read is still ignored, and a write on the third edge is accepted.
- R7: The data output enable is 1 exactly when chip select is 0 and the direction bit is 0 (read).
- R8: While a direction's reset is low, its mailbox word and full flag are cleared and its FIFO strobes stay low. Reading that mailbox after reset returns 0.
- R9: The two directions are independent. Resetting one direction leaves the other mailbox's flag and word intact.
- R10: A mailbox read while the receiving flag is 0 returns the current register contents and leaves the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst1_n | input | 1 | Asynchronous reset of direction 1 (A to B), active low |
| rst2_n | input | 1 | Asynchronous reset of direction 2 (B to A), active low |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_w_nr | input | 1 | Port A direction, 1 write, 0 read |
| a_en | input | 1 | Port A enable |
| a_mb_sel | input | 1 | Port A mailbox select |
| a_din | input | 36 | Port A write data |
| a_dout | output | 36 | Port A read data register |
| a_oe | output | 1 | Port A data output enable |
| a_mail_full | output | 1 | Direction 2 mailbox full, in clk_a domain |
| f1_push | output | 1 | Push strobe into direction 1 FIFO |
| f1_wdata | output | 36 | Direction 1 FIFO write data |
| f1_push_ok | input | 1 | Direction 1 FIFO can accept a word |
| f2_pop | output | 1 | Pop strobe from direction 2 FIFO (port A side) |
| f2_rdata | input | 36 | Direction 2 FIFO head word |
| f2_pop_ok | input | 1 | Direction 2 FIFO holds a word |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_w_nr | input | 1 | Port B direction, 1 write, 0 read |
| b_en | input | 1 | Port B enable |
| b_mb_sel | input | 1 | Port B mailbox select |
| b_din | input | 36 | Port B write data |
| b_dout | output | 36 | Port B read data register |
| b_oe | output | 1 | Port B data output enable |
| b_mail_full | output | 1 | Direction 1 mailbox full, in clk_b domain |
| f2_push | output | 1 | Push strobe into direction 2 FIFO |
| f2_wdata | output | 36 | Direction 2 FIFO write data |
| f2_push_ok | input | 1 | Direction 2 FIFO can accept a word |
| f1_pop | output | 1 | Pop strobe from direction 1 FIFO (port B side) |
| f1_rdata | input | 36 | Direction 1 FIFO head word |
| f1_pop_ok | input | 1 | Direction 1 FIFO holds a word |

## Verification
A corrupted toggle or synchronizer state would show at the ports as a full flag that never rises, rises without a write, or does not drop at the edge after a read. The bench times each of these edges exactly: two edges for the flag to rise, and three edges before the sender can refill. A stored word that changes while full, or a read register that loads from the wrong source, shows one edge later as a wrong word on the data output. The bench compares that word with the value it wrote. Decode faults show up in the same cycle as a wrong combinational push, pop or output-enable level, and the random phase compares these levels against a bench model on every cycle.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  localparam int unsigned DEF_WIDTH = 36;
  localparam int unsigned DEF_SYNC  = 2;

  typedef struct packed {
    logic push;
    logic pop;
    logic mwr;
    logic mrd;
  } acc_t;
endpackage

// File: rtl/mbx_rst_sync.sv
`timescale 1ns/1ps
module mbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] q;
  logic [STAGES-1:0] q_d;

  always_comb begin
    q_d = {q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= q_d;
  end

  assign srst_n = q[STAGES-1];
endmodule

// File: rtl/mbx_bit_sync.sv
`timescale 1ns/1ps
module mbx_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= sr_d;
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
`timescale 1ns/1ps
module mbx_channel #(
  parameter int unsigned WIDTH = mbx_pkg::DEF_WIDTH,
  parameter int unsigned SYNC  = mbx_pkg::DEF_SYNC
) (
  input  logic             clk_s,
  input  logic             rst_s_n,
  input  logic             clk_r,
  input  logic             rst_r_n,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd,
  output logic [WIDTH-1:0] rdata,
  output logic             full_r
);
  // sender domain
  logic             send_tog_q, send_tog_d;
  logic [WIDTH-1:0] word_q, word_d;
  logic             take_s;
  logic             full_s;
  logic             accept;

  // receiver domain
  logic             take_tog_q, take_tog_d;
  logic             send_r;
  logic             take;

  mbx_bit_sync #(.STAGES(SYNC)) u_take_sync (
    .clk(clk_s), .rst_n(rst_s_n), .d(take_tog_q), .q(take_s)
  );

  mbx_bit_sync #(.STAGES(SYNC)) u_send_sync (
    .clk(clk_r), .rst_n(rst_r_n), .d(send_tog_q), .q(send_r)
  );

  always_comb begin
    full_s     = send_tog_q ^ take_s;
    accept     = wr & ~full_s;
    send_tog_d = send_tog_q ^ accept;
    word_d     = accept ? wdata : word_q;
  end

  always_ff @(posedge clk_s or negedge rst_s_n) begin
    if (!rst_s_n) begin
      send_tog_q <= 1'b0;
      word_q     <= '0;
    end else begin
      send_tog_q <= send_tog_d;
      word_q     <= word_d;
    end
  end

  always_comb begin
    full_r     = send_r ^ take_tog_q;
    take       = rd & full_r;
    take_tog_d = take_tog_q ^ take;
  end

  always_ff @(posedge clk_r or negedge rst_r_n) begin
    if (!rst_r_n) take_tog_q <= 1'b0;
    else          take_tog_q <= take_tog_d;
  end

  assign rdata = word_q;

  // R4
  accept_sets_full_chk: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    accept |=> full_s);

  // R5
  word_hold_chk: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    full_s |=> $stable(word_q));

  // R6
  take_clears_chk: assert property (@(posedge clk_r) disable iff (!rst_r_n)
    take |=> !full_r);
endmodule

// File: rtl/mbx_port_ctrl.sv
`timescale 1ns/1ps
module mbx_port_ctrl #(
  parameter int unsigned WIDTH = mbx_pkg::DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_out_n,
  input  logic             rst_in_n,
  input  logic             cs_n,
  input  logic             w_nr,
  input  logic             en,
  input  logic             mb_sel,
  input  logic             push_ok,
  input  logic             pop_ok,
  input  logic [WIDTH-1:0] fifo_rdata,
  input  logic [WIDTH-1:0] mail_in,
  output logic             push,
  output logic             pop,
  output logic             mail_wr,
  output logic             mail_rd,
  output logic [WIDTH-1:0] dout,
  output logic             oe
);
  import mbx_pkg::*;

  acc_t             acc;
  logic             sel;
  logic             wr_acc, rd_acc;
  logic [WIDTH-1:0] dout_q, dout_d;

  always_comb begin
    sel      = ~cs_n & en;
    wr_acc   = sel & w_nr;
    rd_acc   = sel & ~w_nr;
    acc.push = wr_acc & ~mb_sel & push_ok & rst_out_n;
    acc.mwr  = wr_acc &  mb_sel & rst_out_n;
    acc.pop  = rd_acc & ~mb_sel & pop_ok & rst_in_n;
    acc.mrd  = rd_acc &  mb_sel & rst_in_n;
  end

  always_comb begin
    dout_d = dout_q;
    if (acc.pop)      dout_d = fifo_rdata;
    else if (acc.mrd) dout_d = mail_in;
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) dout_q <= '0;
    else           dout_q <= dout_d;
  end

  assign push    = acc.push;
  assign pop     = acc.pop;
  assign mail_wr = acc.mwr;
  assign mail_rd = acc.mrd;
  assign dout    = dout_q;
  assign oe      = ~cs_n & ~w_nr;

  // R1
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
    $onehot0({push, pop, mail_wr, mail_rd}));

  // R3
  pop_load_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
    pop |=> dout == $past(fifo_rdata));

  // R6
  mail_load_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
    mail_rd |=> dout == $past(mail_in));
endmodule

// File: rtl/mbx_bypass_ctrl.sv
`timescale 1ns/1ps
module mbx_bypass_ctrl #(
  parameter int unsigned WIDTH = mbx_pkg::DEF_WIDTH,
  parameter int unsigned SYNC  = mbx_pkg::DEF_SYNC
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             rst1_n,
  input  logic             rst2_n,
  input  logic             a_cs_n,
  input  logic             a_w_nr,
  input  logic             a_en,
  input  logic             a_mb_sel,
  input  logic [WIDTH-1:0] a_din,
  output logic [WIDTH-1:0] a_dout,
  output logic             a_oe,
  output logic             a_mail_full,
  output logic             f1_push,
  output logic [WIDTH-1:0] f1_wdata,
  input  logic             f1_push_ok,
  output logic             f2_pop,
  input  logic [WIDTH-1:0] f2_rdata,
  input  logic             f2_pop_ok,
  input  logic             b_cs_n,
  input  logic             b_w_nr,
  input  logic             b_en,
  input  logic             b_mb_sel,
  input  logic [WIDTH-1:0] b_din,
  output logic [WIDTH-1:0] b_dout,
  output logic             b_oe,
  output logic             b_mail_full,
  output logic             f2_push,
  output logic [WIDTH-1:0] f2_wdata,
  input  logic             f2_push_ok,
  output logic             f1_pop,
  input  logic [WIDTH-1:0] f1_rdata,
  input  logic             f1_pop_ok
);
  localparam int unsigned NDIR = 2;

  logic             clk_p   [NDIR];
  logic             rst_dir [NDIR];
  logic             srst    [NDIR][NDIR];   // [direction][port domain]
  logic             mwr     [NDIR];         // by sending port
  logic [WIDTH-1:0] mwdata  [NDIR];
  logic             mrd     [NDIR];         // by reading port
  logic [WIDTH-1:0] mdata   [NDIR];         // by direction
  logic             mfull   [NDIR];         // by direction, receiver domain

  assign clk_p[0]   = clk_a;
  assign clk_p[1]   = clk_b;
  assign rst_dir[0] = rst1_n;
  assign rst_dir[1] = rst2_n;
  assign mwdata[0]  = a_din;
  assign mwdata[1]  = b_din;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    for (genvar p = 0; p < NDIR; p++) begin : g_dom
      mbx_rst_sync #(.STAGES(SYNC)) u_rsync (
        .clk(clk_p[p]), .arst_n(rst_dir[d]), .srst_n(srst[d][p])
      );
    end

    // direction d: sent by port d, received by port 1-d
    mbx_channel #(.WIDTH(WIDTH), .SYNC(SYNC)) u_chan (
      .clk_s  (clk_p[d]),
      .rst_s_n(srst[d][d]),
      .clk_r  (clk_p[1-d]),
      .rst_r_n(srst[d][1-d]),
      .wr     (mwr[d]),
      .wdata  (mwdata[d]),
      .rd     (mrd[1-d]),
      .rdata  (mdata[d]),
      .full_r (mfull[d])
    );
  end

  mbx_port_ctrl #(.WIDTH(WIDTH)) u_port_a (
    .clk       (clk_a),
    .rst_out_n (srst[0][0]),
    .rst_in_n  (srst[1][0]),
    .cs_n      (a_cs_n),
    .w_nr      (a_w_nr),
    .en        (a_en),
    .mb_sel    (a_mb_sel),
    .push_ok   (f1_push_ok),
    .pop_ok    (f2_pop_ok),
    .fifo_rdata(f2_rdata),
    .mail_in   (mdata[1]),
    .push      (f1_push),
    .pop       (f2_pop),
    .mail_wr   (mwr[0]),
    .mail_rd   (mrd[0]),
    .dout      (a_dout),
    .oe        (a_oe)
  );

  mbx_port_ctrl #(.WIDTH(WIDTH)) u_port_b (
    .clk       (clk_b),
    .rst_out_n (srst[1][1]),
    .rst_in_n  (srst[0][1]),
    .cs_n      (b_cs_n),
    .w_nr      (b_w_nr),
    .en        (b_en),
    .mb_sel    (b_mb_sel),
    .push_ok   (f2_push_ok),
    .pop_ok    (f1_pop_ok),
    .fifo_rdata(f1_rdata),
    .mail_in   (mdata[0]),
    .push      (f2_push),
    .pop       (f1_pop),
    .mail_wr   (mwr[1]),
    .mail_rd   (mrd[1]),
    .dout      (b_dout),
    .oe        (b_oe)
  );

  assign f1_wdata    = a_din;
  assign f2_wdata    = b_din;
  assign b_mail_full = mfull[0];
  assign a_mail_full = mfull[1];
endmodule

// File: tb/sim_mbx_bypass_ctrl.sv
`timescale 1ns/1ps
module sim_mbx_bypass_ctrl;
  localparam int W = 36;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst1_n, rst2_n;
  logic a_cs_n, a_w_nr, a_en, a_mb_sel; logic [W-1:0] a_din, a_dout; logic a_oe, a_mail_full;
  logic b_cs_n, b_w_nr, b_en, b_mb_sel; logic [W-1:0] b_din, b_dout; logic b_oe, b_mail_full;
  logic f1_push, f1_push_ok, f2_pop, f2_pop_ok, f2_push, f2_push_ok, f1_pop, f1_pop_ok;
  logic [W-1:0] f1_wdata, f2_rdata, f2_wdata, f1_rdata;

  mbx_bypass_ctrl u0 (
    .clk_a(clk), .clk_b(clk), .rst1_n(rst1_n), .rst2_n(rst2_n),
    .a_cs_n(a_cs_n), .a_w_nr(a_w_nr), .a_en(a_en), .a_mb_sel(a_mb_sel), .a_din(a_din),
    .a_dout(a_dout), .a_oe(a_oe), .a_mail_full(a_mail_full),
    .f1_push(f1_push), .f1_wdata(f1_wdata), .f1_push_ok(f1_push_ok),
    .f2_pop(f2_pop), .f2_rdata(f2_rdata), .f2_pop_ok(f2_pop_ok),
    .b_cs_n(b_cs_n), .b_w_nr(b_w_nr), .b_en(b_en), .b_mb_sel(b_mb_sel), .b_din(b_din),
    .b_dout(b_dout), .b_oe(b_oe), .b_mail_full(b_mail_full),
    .f2_push(f2_push), .f2_wdata(f2_wdata), .f2_push_ok(f2_push_ok),
    .f1_pop(f1_pop), .f1_rdata(f1_rdata), .f1_pop_ok(f1_pop_ok)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    check(act === exp, req, act, exp);
  endtask

  function automatic bit exp_push(input logic cs_n, input logic en, input logic w_nr, input logic mb, input logic ok);
    return !cs_n && en && w_nr && !mb && ok;
  endfunction

  function automatic bit exp_pop(input logic cs_n, input logic en, input logic w_nr, input logic mb, input logic ok);
    return !cs_n && en && !w_nr && !mb && ok;
  endfunction

  function automatic bit exp_oe(input logic cs_n, input logic w_nr);
    return !cs_n && !w_nr;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle_a(); a_cs_n = 1; a_w_nr = 0; a_en = 0; a_mb_sel = 0; endtask
  task automatic idle_b(); b_cs_n = 1; b_w_nr = 0; b_en = 0; b_mb_sel = 0; endtask

  task automatic a_mwrite(input logic [W-1:0] d);
    a_cs_n = 0; a_w_nr = 1; a_en = 1; a_mb_sel = 1; a_din = d; step(); idle_a();
  endtask
  task automatic b_mwrite(input logic [W-1:0] d);
    b_cs_n = 0; b_w_nr = 1; b_en = 1; b_mb_sel = 1; b_din = d; step(); idle_b();
  endtask
  task automatic a_mread(); a_cs_n = 0; a_w_nr = 0; a_en = 1; a_mb_sel = 1; step(); idle_a(); endtask
  task automatic b_mread(); b_cs_n = 0; b_w_nr = 0; b_en = 1; b_mb_sel = 1; step(); idle_b(); endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] ea, eb;
    void'($urandom(32'd4242));
    rst1_n = 0; rst2_n = 0;
    idle_a(); idle_b();
    a_din = '0; b_din = '0; f1_rdata = '0; f2_rdata = '0;
    f1_push_ok = 1; f2_push_ok = 1; f1_pop_ok = 1; f2_pop_ok = 1;
    step(); step();
    // R8: reset state and strobes held low during reset
    chk("R8 b_mail_full reset", b_mail_full, 0);
    chk("R8 a_mail_full reset", a_mail_full, 0);
    chk("R8 a_dout reset", a_dout, 0);
    a_cs_n = 0; a_en = 1; a_w_nr = 1; #0.5;
    chk("R8 push blocked in reset", f1_push, 0);
    idle_a();
    step();
    rst1_n = 1; rst2_n = 1;
    step(); step(); step();

    // R1 R2 R3 R7: random FIFO-path traffic
    ea = a_dout; eb = b_dout;
    for (int i = 0; i < 400; i++) begin
      a_cs_n = 1'($urandom); a_w_nr = 1'($urandom); a_en = 1'($urandom); a_mb_sel = 0;
      b_cs_n = 1'($urandom); b_w_nr = 1'($urandom); b_en = 1'($urandom); b_mb_sel = 0;
      a_din = {4'($urandom), 32'($urandom)}; b_din = {4'($urandom), 32'($urandom)};
      f1_rdata = {4'($urandom), 32'($urandom)}; f2_rdata = {4'($urandom), 32'($urandom)};
      f1_push_ok = 1'($urandom); f2_push_ok = 1'($urandom);
      f1_pop_ok = 1'($urandom); f2_pop_ok = 1'($urandom);
      #0.5;
      chk("R2 f1_push", f1_push, exp_push(a_cs_n, a_en, a_w_nr, 0, f1_push_ok));
      chk("R2 f2_push", f2_push, exp_push(b_cs_n, b_en, b_w_nr, 0, f2_push_ok));
      chk("R2 f1_wdata", f1_wdata, a_din);
      chk("R3 f2_pop", f2_pop, exp_pop(a_cs_n, a_en, a_w_nr, 0, f2_pop_ok));
      chk("R3 f1_pop", f1_pop, exp_pop(b_cs_n, b_en, b_w_nr, 0, f1_pop_ok));
      chk("R7 a_oe", a_oe, exp_oe(a_cs_n, a_w_nr));
      chk("R7 b_oe", b_oe, exp_oe(b_cs_n, b_w_nr));
      if (exp_pop(a_cs_n, a_en, a_w_nr, 0, f2_pop_ok)) ea = f2_rdata;
      if (exp_pop(b_cs_n, b_en, b_w_nr, 0, f1_pop_ok)) eb = f1_rdata;
      step();
      chk("R3 a_dout", a_dout, ea);
      chk("R3 b_dout", b_dout, eb);
      chk("R1 no mail flag", b_mail_full, 0);
    end
    idle_a(); idle_b();
    f1_push_ok = 1; f2_push_ok = 1; f1_pop_ok = 1; f2_pop_ok = 1;
    step();

    // R4: flag rises two edges after the write edge
    a_mwrite(36'hA_1111_0001);
    chk("R4 flag after write edge", b_mail_full, 0);
    step(); chk("R4 flag after 1 edge", b_mail_full, 0);
    step(); chk("R4 flag after 2 edges", b_mail_full, 1);

    // R5: write while full ignored
    a_mwrite(36'h5_2222_0002);
    step(); step(); step();
    chk("R5 flag still set", b_mail_full, 1);
    b_mread();
    chk("R5 R6 word kept", b_dout, 36'hA_1111_0001);
    chk("R6 flag cleared by read", b_mail_full, 0);

    // R6: write at read+2 ignored, write at read+3 accepted
    step();                       // read+1
    a_mwrite(36'h3_3333_0003);    // read+2
    a_mwrite(36'hC_4444_0004);    // read+3
    step(); chk("R6 ignored write no flag", b_mail_full, 0);
    step(); chk("R6 accepted write flag", b_mail_full, 1);
    b_mread();
    chk("R6 accepted word", b_dout, 36'hC_4444_0004);

    // R10: read of empty mailbox
    b_mread();
    chk("R10 empty read word", b_dout, 36'hC_4444_0004);
    chk("R10 empty read flag", b_mail_full, 0);

    // R1: no access without chip select / enable
    step(); step();
    a_cs_n = 1; a_en = 1; a_w_nr = 1; a_mb_sel = 1; a_din = 36'hF_5555_0005; step();
    a_cs_n = 0; a_en = 0; step(); idle_a();
    step(); step(); step();
    chk("R1 mailbox untouched flag", b_mail_full, 0);
    b_mread();
    chk("R1 mailbox untouched word", b_dout, 36'hC_4444_0004);

    // R8 R9: reset of direction 1 only
    b_mwrite(36'h7_6666_0006);
    a_mwrite(36'h9_7777_0007);
    step(); step(); step();
    chk("R9 dir2 loaded", a_mail_full, 1);
    chk("R8 dir1 loaded", b_mail_full, 1);
    rst1_n = 0; #0.5;
    chk("R8 flag cleared by reset", b_mail_full, 0);
    chk("R9 dir2 flag kept", a_mail_full, 1);
    step(); rst1_n = 1;
    step(); step(); step();
    b_mread();
    chk("R8 word cleared", b_dout, 0);
    a_mread();
    chk("R9 dir2 word kept", a_dout, 36'h7_6666_0006);
    chk("R9 dir2 flag cleared by read", a_mail_full, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule